// File: doc/BRIEF.md
# Indirect 64-bit Register Access Bridge

The bridge sits on a narrow 32-bit register port and gives a host access to a 64-bit register space that it cannot address directly. The host puts the two halves of a 64-bit value into two data words and then writes a command word. The command holds a direction flag in its top bit and a register offset in its other 31 bits. Writing the command starts exactly one access on a request/acknowledge port toward the wide space. A read access returns its 64-bit result into the same two data words.

Failures are collected in one sticky flag: an access that the far side refuses, an access that gets no reply in time, and a command issued while an earlier access is still running. The flag stays set until the host writes the clear word. A busy bit lets the host poll for completion, and an optional interrupt output follows the flag when it is enabled. Far-side addresses are the instance base (0x70000 by default) plus the command offset.

Top module: `ind64_bridge`

## Requirements
- R1: Window map, decoded on the full 8-bit address: 0x00 high data word (bits 63:32), 0x04 low data word (bits 31:0), 0x08 command (the last value written reads back), 0x18 flag clear, 0x1C status, 0x20 interrupt enable. Reads return data in the same cycle, and any other address reads as zero.
- R2: A command write with bit 31 = 1 starts a far-side write. From the next cycle rmt_req = 1 and rmt_wr = 1, and rmt_wdata = {high word, low word} as they were when the command was written.
- R3: rmt_addr = BASE_ADDR + command bits 30:0, taken modulo 2^32.
- R4: A command write with bit 31 = 0 starts a far-side read (rmt_wr = 0). On an error-free acknowledge, rmt_rdata[63:32] goes to the high word and rmt_rdata[31:0] to the low word. Both are readable in the cycle after the acknowledge.
- R5: rmt_req stays high until it is acknowledged, and rmt_addr, rmt_wr and rmt_wdata stay unchanged meanwhile, even if the data words are rewritten. Status bit 0 reads 1 exactly while rmt_req is high.
- R6: An acknowledge that comes with rmt_err = 1 ends the access and sets the sticky error flag (status bit 31). A read that fails this way leaves both data words unchanged.
- R7: If no acknowledge arrives, rmt_req is withdrawn after exactly TIMEOUT_CYC cycles high and the error flag is set.
- R8: A command written while an access is in flight is dropped. The running access keeps its address, direction and data, the dropped command is never issued, and the error flag is set.
- R9: The error flag is cleared only by a write of any value to 0x18. Writes to other addresses do not clear it, and when a new error and a clear arrive in the same cycle, the error wins.
- R10: irq = error flag AND interrupt-enable bit 0. Offset 0x20 reads back only bit 0.
- R11: After reset the data words, command, status and enable read 0, and rmt_req and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 1 | Host register access valid |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 8 | Window byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, same cycle |
| rmt_req | output | 1 | Far-side access request, held until acknowledged or expired |
| rmt_wr | output | 1 | Far-side direction, 1 = write |
| rmt_addr | output | 32 | Far-side register address |
| rmt_wdata | output | 64 | Far-side write data |
| rmt_ack | input | 1 | Far-side acknowledge, one cycle |
| rmt_err | input | 1 | Far-side error, qualified by rmt_ack |
| rmt_rdata | input | 64 | Far-side read data, qualified by rmt_ack |
| irq | output | 1 | Error interrupt, gated by the enable bit |

## Verification
The command path is driven with a write to a small offset, a read with distinct data in each half, and an offset near the top of the 31-bit range. Together these show whether the halves are swapped, whether the direction bit is decoded, and whether the base addition carries correctly. Far-side replies are varied: a clean acknowledge after a delay, an acknowledge with error, and no reply at all. These separate data loading, error latching with the data words left alone, and the exact length of the timeout. A second command during a pending read, and a clear that lands in the same cycle as a new error, exercise dropping and the priority of setting the flag over clearing it.

// File: rtl/ind64_pkg.sv
package ind64_pkg;

    localparam int WIN_AW = 8;
    localparam int HDW    = 32;
    localparam int WDW    = 2 * HDW;

    localparam logic [WIN_AW-1:0] OFS_DHI  = 8'h00;
    localparam logic [WIN_AW-1:0] OFS_DLO  = 8'h04;
    localparam logic [WIN_AW-1:0] OFS_CMD  = 8'h08;
    localparam logic [WIN_AW-1:0] OFS_CLR  = 8'h18;
    localparam logic [WIN_AW-1:0] OFS_STAT = 8'h1C;
    localparam logic [WIN_AW-1:0] OFS_IRQ  = 8'h20;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_ERR_BIT  = HDW - 1;

    typedef struct packed {
        logic            is_write;
        logic [HDW-2:0]  offset;
    } cmd_t;

    typedef struct packed {
        logic            wr;
        logic [HDW-1:0]  addr;
        logic [WDW-1:0]  data;
    } remote_req_t;

    typedef enum logic {
        ENG_IDLE,
        ENG_WAIT
    } eng_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DHI,
        SEL_DLO,
        SEL_CMD,
        SEL_CLR,
        SEL_STAT,
        SEL_IRQ
    } win_sel_e;

    function automatic win_sel_e decode_window(input logic [WIN_AW-1:0] a);
        win_sel_e s;
        case (a)
            OFS_DHI:  s = SEL_DHI;
            OFS_DLO:  s = SEL_DLO;
            OFS_CMD:  s = SEL_CMD;
            OFS_CLR:  s = SEL_CLR;
            OFS_STAT: s = SEL_STAT;
            OFS_IRQ:  s = SEL_IRQ;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [HDW-1:0] far_address(input logic [HDW-1:0] base,
                                                   input logic [HDW-2:0] ofs);
        return base + {1'b0, ofs};
    endfunction

endpackage

// File: rtl/ind64_regwin.sv
module ind64_regwin
    import ind64_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_sel,
    input  logic              hst_wr,
    input  logic [WIN_AW-1:0] hst_addr,
    input  logic [HDW-1:0]    hst_wdata,
    output logic [HDW-1:0]    hst_rdata,
    input  logic              busy,
    input  logic              err_flag,
    input  logic              ld_en,
    input  logic [WDW-1:0]    ld_data,
    output logic              cmd_fire,
    output cmd_t              cmd_word,
    output logic [WDW-1:0]    stage_data,
    output logic              clr_pulse,
    output logic              irq_en
);

    win_sel_e       sel_w;
    logic           wr_hit;
    logic           rd_hit;
    logic [HDW-1:0] dhi_q;
    logic [HDW-1:0] dlo_q;
    logic [HDW-1:0] cmd_q;
    logic           irq_en_q;
    logic [HDW-1:0] stat_w;

    assign sel_w  = decode_window(hst_addr);
    assign wr_hit = hst_sel &&  hst_wr;
    assign rd_hit = hst_sel && !hst_wr;

    // Far-side read completion loads first; a host write in the same cycle overrides it.
    always_ff @(posedge clk) begin
        if (rst) begin
            dhi_q    <= '0;
            dlo_q    <= '0;
            cmd_q    <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (ld_en) begin
                dhi_q <= ld_data[WDW-1:HDW];
                dlo_q <= ld_data[HDW-1:0];
            end
            if (wr_hit && sel_w == SEL_DHI) dhi_q    <= hst_wdata;
            if (wr_hit && sel_w == SEL_DLO) dlo_q    <= hst_wdata;
            if (wr_hit && sel_w == SEL_CMD) cmd_q    <= hst_wdata;
            if (wr_hit && sel_w == SEL_IRQ) irq_en_q <= hst_wdata[0];
        end
    end

    always_comb begin
        stat_w                = '0;
        stat_w[STAT_BUSY_BIT] = busy;
        stat_w[STAT_ERR_BIT]  = err_flag;
    end

    always_comb begin
        hst_rdata = '0;
        if (rd_hit) begin
            case (sel_w)
                SEL_DHI:  hst_rdata = dhi_q;
                SEL_DLO:  hst_rdata = dlo_q;
                SEL_CMD:  hst_rdata = cmd_q;
                SEL_STAT: hst_rdata = stat_w;
                SEL_IRQ:  hst_rdata = {{(HDW-1){1'b0}}, irq_en_q};
                default:  hst_rdata = '0;
            endcase
        end
    end

    assign cmd_fire   = wr_hit && (sel_w == SEL_CMD);
    assign cmd_word   = cmd_t'(hst_wdata);
    assign stage_data = {dhi_q, dlo_q};
    assign clr_pulse  = wr_hit && (sel_w == SEL_CLR);
    assign irq_en     = irq_en_q;

endmodule

// File: rtl/ind64_engine.sv
module ind64_engine
    import ind64_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h0007_0000,
    parameter int          TIMEOUT_CYC = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_fire,
    input  cmd_t           cmd_word,
    input  logic [WDW-1:0] stage_data,
    output logic           busy,
    output logic           rmt_req,
    output logic           rmt_wr,
    output logic [HDW-1:0] rmt_addr,
    output logic [WDW-1:0] rmt_wdata,
    input  logic           rmt_ack,
    input  logic           rmt_err,
    input  logic [WDW-1:0] rmt_rdata,
    output logic           ld_en,
    output logic [WDW-1:0] ld_data,
    output logic           ev_fault,
    output logic           ev_drop
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    eng_state_e  state_q;
    remote_req_t req_q;
    logic [CNT_W-1:0] wait_cnt_q;
    logic        in_wait;
    logic        accept;
    logic        done_ok;
    logic        done_bad;
    logic        expire;

    assign in_wait  = (state_q == ENG_WAIT);
    assign accept   = cmd_fire && !in_wait;
    assign done_ok  = in_wait &&  rmt_ack && !rmt_err;
    assign done_bad = in_wait &&  rmt_ack &&  rmt_err;
    assign expire   = in_wait && !rmt_ack && (wait_cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ENG_IDLE;
            req_q      <= '0;
            wait_cnt_q <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (accept) begin
                        state_q    <= ENG_WAIT;
                        req_q      <= '{wr:   cmd_word.is_write,
                                        addr: far_address(BASE_ADDR, cmd_word.offset),
                                        data: stage_data};
                        wait_cnt_q <= '0;
                    end
                end
                ENG_WAIT: begin
                    if (rmt_ack || expire) begin
                        state_q <= ENG_IDLE;
                    end else begin
                        wait_cnt_q <= wait_cnt_q + 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy      = in_wait;
    assign rmt_req   = in_wait;
    assign rmt_wr    = req_q.wr;
    assign rmt_addr  = req_q.addr;
    assign rmt_wdata = req_q.data;

    assign ld_en    = done_ok && !req_q.wr;
    assign ld_data  = rmt_rdata;
    assign ev_fault = done_bad || expire;
    assign ev_drop  = cmd_fire && in_wait;

endmodule

// File: rtl/ind64_errlatch.sv
module ind64_errlatch (
    input  logic clk,
    input  logic rst,
    input  logic set_fault,
    input  logic set_drop,
    input  logic clr,
    output logic err_flag
);

    logic err_q;

    // Setting takes priority over clearing.
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (set_fault || set_drop) begin
            err_q <= 1'b1;
        end else if (clr) begin
            err_q <= 1'b0;
        end
    end

    assign err_flag = err_q;

endmodule

// File: rtl/ind64_bridge.sv
module ind64_bridge
    import ind64_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h0007_0000,
    parameter int          TIMEOUT_CYC = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hst_sel,
    input  logic        hst_wr,
    input  logic [7:0]  hst_addr,
    input  logic [31:0] hst_wdata,
    output logic [31:0] hst_rdata,
    output logic        rmt_req,
    output logic        rmt_wr,
    output logic [31:0] rmt_addr,
    output logic [63:0] rmt_wdata,
    input  logic        rmt_ack,
    input  logic        rmt_err,
    input  logic [63:0] rmt_rdata,
    output logic        irq
);

    logic           busy;
    logic           err_flag;
    logic           ld_en;
    logic [WDW-1:0] ld_data;
    logic           cmd_fire;
    cmd_t           cmd_word;
    logic [WDW-1:0] stage_data;
    logic           clr_pulse;
    logic           irq_en;
    logic           ev_fault;
    logic           ev_drop;

    ind64_regwin u_win (
        .clk        (clk),
        .rst        (rst),
        .hst_sel    (hst_sel),
        .hst_wr     (hst_wr),
        .hst_addr   (hst_addr),
        .hst_wdata  (hst_wdata),
        .hst_rdata  (hst_rdata),
        .busy       (busy),
        .err_flag   (err_flag),
        .ld_en      (ld_en),
        .ld_data    (ld_data),
        .cmd_fire   (cmd_fire),
        .cmd_word   (cmd_word),
        .stage_data (stage_data),
        .clr_pulse  (clr_pulse),
        .irq_en     (irq_en)
    );

    ind64_engine #(
        .BASE_ADDR   (BASE_ADDR),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .cmd_fire   (cmd_fire),
        .cmd_word   (cmd_word),
        .stage_data (stage_data),
        .busy       (busy),
        .rmt_req    (rmt_req),
        .rmt_wr     (rmt_wr),
        .rmt_addr   (rmt_addr),
        .rmt_wdata  (rmt_wdata),
        .rmt_ack    (rmt_ack),
        .rmt_err    (rmt_err),
        .rmt_rdata  (rmt_rdata),
        .ld_en      (ld_en),
        .ld_data    (ld_data),
        .ev_fault   (ev_fault),
        .ev_drop    (ev_drop)
    );

    ind64_errlatch u_err (
        .clk       (clk),
        .rst       (rst),
        .set_fault (ev_fault),
        .set_drop  (ev_drop),
        .clr       (clr_pulse),
        .err_flag  (err_flag)
    );

    assign irq = err_flag && irq_en;

endmodule

// File: rtl/ind64_bridge_chk.sv
module ind64_bridge_chk
    import ind64_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h0007_0000,
    parameter int          TIMEOUT_CYC = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        hst_sel,
    input logic        hst_wr,
    input logic [7:0]  hst_addr,
    input logic [31:0] hst_wdata,
    input logic [31:0] hst_rdata,
    input logic        rmt_req,
    input logic        rmt_wr,
    input logic [31:0] rmt_addr,
    input logic [63:0] rmt_wdata,
    input logic        rmt_ack,
    input logic        rmt_err,
    input logic        irq,
    input logic        err_flag
);

    int  hi_cnt;
    logic cmd_wr;
    logic clr_wr;

    assign cmd_wr = hst_sel && hst_wr && (hst_addr == OFS_CMD);
    assign clr_wr = hst_sel && hst_wr && (hst_addr == OFS_CLR);

    always_ff @(posedge clk) begin
        if (rst || !rmt_req) hi_cnt <= 0;
        else                 hi_cnt <= hi_cnt + 1;
    end

    p_fire_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !rmt_req) |=> (rmt_req && rmt_wr == $past(hst_wdata[31])));

    p_fire_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !rmt_req) |=> (rmt_addr == BASE_ADDR + {1'b0, $past(hst_wdata[30:0])}));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rmt_req && !rmt_ack && hi_cnt < TIMEOUT_CYC - 1) |=>
        (rmt_req && $stable(rmt_addr) && $stable(rmt_wr) && $stable(rmt_wdata)));

    p_busy_view_r5: assert property (@(posedge clk) disable iff (rst)
        (hst_sel && !hst_wr && hst_addr == OFS_STAT) |->
        (hst_rdata[0] == rmt_req && hst_rdata[31] == err_flag));

    p_fault_r6: assert property (@(posedge clk) disable iff (rst)
        (rmt_req && rmt_ack && rmt_err) |=> err_flag);

    p_expire_r7: assert property (@(posedge clk) disable iff (rst)
        (rmt_req && !rmt_ack && hi_cnt == TIMEOUT_CYC - 1) |=> (!rmt_req && err_flag));

    p_window_bound_r7: assert property (@(posedge clk) disable iff (rst)
        rmt_req |-> (hi_cnt < TIMEOUT_CYC));

    p_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && rmt_req) |=> err_flag);

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr_wr) |=> err_flag);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> err_flag);

endmodule

bind ind64_bridge ind64_bridge_chk #(
    .BASE_ADDR   (BASE_ADDR),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hst_sel   (hst_sel),
    .hst_wr    (hst_wr),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .rmt_req   (rmt_req),
    .rmt_wr    (rmt_wr),
    .rmt_addr  (rmt_addr),
    .rmt_wdata (rmt_wdata),
    .rmt_ack   (rmt_ack),
    .rmt_err   (rmt_err),
    .irq       (irq),
    .err_flag  (err_flag)
);

// File: tb/ind64_bridge_tb.sv
module ind64_bridge_tb;

    localparam int TO = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_sel = 1'b0;
    logic        hst_wr = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        rmt_req;
    logic        rmt_wr;
    logic [31:0] rmt_addr;
    logic [63:0] rmt_wdata;
    logic        rmt_ack = 1'b0;
    logic        rmt_err = 1'b0;
    logic [63:0] rmt_rdata = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ind64_bridge #(.BASE_ADDR(32'h0007_0000), .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst(rst),
        .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .rmt_req(rmt_req), .rmt_wr(rmt_wr), .rmt_addr(rmt_addr),
        .rmt_wdata(rmt_wdata), .rmt_ack(rmt_ack), .rmt_err(rmt_err),
        .rmt_rdata(rmt_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_sel = 1'b0; hst_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_sel = 1'b1; hst_wr = 1'b0; hst_addr = a;
        #1;
        d = hst_rdata;
        hst_sel = 1'b0;
    endtask

    // Called at a negedge with rmt_req high; returns at the negedge after the acknowledge edge.
    task automatic respond(input int delay, input bit e, input logic [63:0] d);
        for (int i = 0; i < delay; i++) @(negedge clk);
        rmt_ack = 1'b1; rmt_err = e; rmt_rdata = d;
        @(negedge clk);
        rmt_ack = 1'b0; rmt_err = 1'b0; rmt_rdata = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        host_read(8'h00, v); check("R11 high word", v, 0);
        host_read(8'h04, v); check("R11 low word", v, 0);
        host_read(8'h08, v); check("R11 command", v, 0);
        host_read(8'h1C, v); check("R11 status", v, 0);
        host_read(8'h20, v); check("R11 enable", v, 0);
        check("R11 req", rmt_req, 0);
        check("R11 irq", irq, 0);
    endtask

    task automatic t_window;
        logic [31:0] v;
        host_write(8'h00, 32'hA5A5_0001);
        host_write(8'h04, 32'h5A5A_0002);
        host_read(8'h00, v); check("R1 high readback", v, 32'hA5A5_0001);
        host_read(8'h04, v); check("R1 low readback", v, 32'h5A5A_0002);
        host_read(8'h0C, v); check("R1 unmapped", v, 0);
        host_read(8'h01, v); check("R1 partial addr", v, 0);
    endtask

    task automatic t_far_write;
        logic [31:0] v;
        host_write(8'h00, 32'h1122_3344);
        host_write(8'h04, 32'h5566_7788);
        host_write(8'h08, 32'h8000_0005);
        check("R2 req", rmt_req, 1);
        check("R2 dir", rmt_wr, 1);
        check("R2 data", rmt_wdata, 64'h1122_3344_5566_7788);
        check("R3 addr", rmt_addr, 32'h0007_0005);
        host_read(8'h1C, v); check("R5 busy", v, 32'h0000_0001);
        host_read(8'h08, v); check("R1 command readback", v, 32'h8000_0005);
        host_write(8'h00, 32'hDEAD_BEEF);
        check("R5 data held", rmt_wdata, 64'h1122_3344_5566_7788);
        check("R5 req held", rmt_req, 1);
        respond(2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R2 done", rmt_req, 0);
        host_read(8'h1C, v); check("R5 idle status", v, 0);
        host_read(8'h00, v); check("R4 write keeps words", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_far_read;
        logic [31:0] v;
        host_write(8'h08, 32'h0000_0010);
        check("R4 dir", rmt_wr, 0);
        check("R3 read addr", rmt_addr, 32'h0007_0010);
        respond(3, 1'b0, 64'hCAFE_F00D_1234_5678);
        host_read(8'h00, v); check("R4 high", v, 32'hCAFE_F00D);
        host_read(8'h04, v); check("R4 low", v, 32'h1234_5678);
        host_read(8'h1C, v); check("R4 no error", v, 0);
    endtask

    task automatic t_addr_top;
        host_write(8'h08, 32'h7FFF_FFF0);
        check("R3 carry addr", rmt_addr, 32'h8006_FFF0);
        respond(0, 1'b0, 64'h0);
    endtask

    task automatic t_fault;
        logic [31:0] v;
        host_write(8'h00, 32'h0BAD_0001);
        host_write(8'h04, 32'h0BAD_0002);
        host_write(8'h08, 32'h0000_0003);
        respond(1, 1'b1, 64'h9999_8888_7777_6666);
        host_read(8'h1C, v); check("R6 error status", v, 32'h8000_0000);
        host_read(8'h00, v); check("R6 high unchanged", v, 32'h0BAD_0001);
        host_read(8'h04, v); check("R6 low unchanged", v, 32'h0BAD_0002);
        host_write(8'h04, 32'h0);
        host_read(8'h1C, v); check("R9 other write keeps", v, 32'h8000_0000);
        host_write(8'h18, 32'h1234);
        host_read(8'h1C, v); check("R9 cleared", v, 0);
    endtask

    task automatic t_timeout;
        logic [31:0] v;
        int n;
        host_write(8'h08, 32'h8000_0001);
        n = 0;
        while (rmt_req && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check("R7 high cycles", n, TO);
        host_read(8'h1C, v); check("R7 error", v, 32'h8000_0000);
        host_write(8'h18, 32'h0);
    endtask

    task automatic t_drop;
        logic [31:0] v;
        host_write(8'h08, 32'h0000_0020);
        host_write(8'h08, 32'h8000_0040);
        check("R8 addr kept", rmt_addr, 32'h0007_0020);
        check("R8 dir kept", rmt_wr, 0);
        host_read(8'h1C, v); check("R8 error+busy", v, 32'h8000_0001);
        respond(1, 1'b0, 64'h0102_0304_0506_0708);
        host_read(8'h00, v); check("R8 first read data", v, 32'h0102_0304);
        @(negedge clk);
        check("R8 not reissued", rmt_req, 0);
        host_write(8'h18, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        host_write(8'h08, 32'h0000_0002);
        @(negedge clk);
        rmt_ack = 1'b1; rmt_err = 1'b1;
        hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = 8'h18; hst_wdata = '0;
        @(negedge clk);
        rmt_ack = 1'b0; rmt_err = 1'b0; hst_sel = 1'b0; hst_wr = 1'b0;
        host_read(8'h1C, v); check("R9 set beats clear", v, 32'h8000_0000);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        host_write(8'h20, 32'hFFFF_FFFF);
        host_read(8'h20, v); check("R10 enable readback", v, 1);
        check("R10 irq with error", irq, 1);
        host_write(8'h20, 32'h0);
        check("R10 irq masked", irq, 0);
        host_write(8'h20, 32'h1);
        check("R10 irq re-enabled", irq, 1);
        host_write(8'h18, 32'h0);
        check("R10 irq after clear", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_window();
        t_far_write();
        t_far_read();
        t_addr_top();
        t_fault();
        t_timeout();
        t_drop();
        t_set_wins();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule